// File: doc/BRIEF.md
# Frequency Select and Test-Mode Divider

This block turns a three-bit select code into an operating mode. It then produces six clock groups from one master clock: CPU, PCI, free-running PCI, 48 MHz (USB), reference and IOAPIC. Each group is made by integer division of the master clock. The master clock runs at six times the PCI rate. In the two active modes the PCI groups stay near 33 MHz. The CPU group runs at two or three times the PCI rate, depending on the code.

In test mode, an upstream clock multiplexer feeds the test clock in as the master clock, and every group divides it by a fixed ratio. The tri-state mode drops all output enables so the pads float. Reserved codes keep every output low with its enable still driven, and they raise an error flag.

Every division is built at half-cycle resolution: one register changes on the rising master edge and one on the falling edge. This gives odd divisors a duty cycle of exactly one half. A change of mode restarts all the dividers on the same edge, so the groups stay phase aligned.

Top module: `clkgen_freq_sel`

## Requirements
- R1: The select code is synchronised through two master-clock flops and then decoded. Code 000 is tri-state, 011 is the 66 MHz mode, 111 is the 100 MHz mode and 100 is test mode. Codes 001, 010, 101 and 110 are reserved.
- R2: In tri-state mode all six enables (`*_oe`) are 0 and all six clock outputs are low.
- R3: In the 66 MHz mode the CPU output divides the master clock by 3 and is high for 3 of every 6 half-cycles. Both PCI outputs divide it by 6 and are high for 6 of every 12 half-cycles.
- R4: In the 100 MHz mode the CPU output divides the master clock by 2. Both PCI outputs divide it by 6.
- R5: In both active modes the USB output divides the master clock by 4. The reference and IOAPIC outputs divide it by 14. Each is high for the first half of its period.
- R6: In test mode the CPU and USB outputs divide the master clock by 2 and both PCI outputs divide it by 6. The reference and IOAPIC outputs follow the master clock undivided: high in its high half, low in its low half.
- R7: Under a reserved code all six enables are 1, all six clock outputs are low, and `mode_err` is 1. In every other mode `mode_err` is 0.
- R8: Every rising edge of a PCI output falls on the same master edge as a rising edge of the CPU output.
- R9: When the decoded mode changes, every divider restarts on the third rising master edge after the new code is applied. Every running group goes high in the half-cycle that follows that edge.
- R10: During reset and after it with code 000 applied, all clock outputs, all enables and `mode_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; carries the test clock in test mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 3 | Mode select code |
| cpu_ck | output | 1 | CPU clock group |
| pci_ck | output | 1 | Stoppable PCI clock group |
| pcif_ck | output | 1 | Free-running PCI clock |
| usb_ck | output | 1 | 48 MHz group clock |
| ref_ck | output | 1 | Reference group clock |
| apic_ck | output | 1 | IOAPIC group clock |
| cpu_oe | output | 1 | Pad enable for CPU group |
| pci_oe | output | 1 | Pad enable for PCI group |
| pcif_oe | output | 1 | Pad enable for free-running PCI |
| usb_oe | output | 1 | Pad enable for 48 MHz group |
| ref_oe | output | 1 | Pad enable for reference group |
| apic_oe | output | 1 | Pad enable for IOAPIC group |
| mode_err | output | 1 | High while a reserved code is decoded |

## Verification
A new select code takes effect at the third rising master edge after it is driven: two edges pass through the synchroniser and the third is the restart edge. The bench drives each code just after a falling edge and waits exactly three rising edges. It then samples every output 2 ns into each following half-cycle, so half-cycle index zero is the first half-cycle of the new period. Expected levels come from the index modulo twice the divisor. Enables and the error flag settle at that same restart edge, and the bench checks them after the restart sampling window. Before each target code the bench applies a code of a different mode, so that every code in the sweep forces a real restart.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [2:0] {
    MD_FLOAT  = 3'd0,
    MD_RUN66  = 3'd1,
    MD_RUN100 = 3'd2,
    MD_TEST   = 3'd3,
    MD_BAD    = 3'd4
  } clk_mode_e;

  localparam int NGRP     = 6;
  localparam int GRP_CPU  = 0;
  localparam int GRP_PCI  = 1;
  localparam int GRP_PCIF = 2;
  localparam int GRP_USB  = 3;
  localparam int GRP_REF  = 4;
  localparam int GRP_APIC = 5;

  function automatic clk_mode_e decode_code(input logic [2:0] code);
    clk_mode_e m;
    case (code)
      3'b000:  m = MD_FLOAT;
      3'b011:  m = MD_RUN66;
      3'b111:  m = MD_RUN100;
      3'b100:  m = MD_TEST;
      default: m = MD_BAD;
    endcase
    return m;
  endfunction

  function automatic logic mode_runs(input clk_mode_e m);
    return (m == MD_RUN66) || (m == MD_RUN100) || (m == MD_TEST);
  endfunction

endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_mode_decode.sv
module clkgen_mode_decode
  import clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [2:0] code_in,
  output clk_mode_e mode_nx,
  output clk_mode_e mode_cur,
  output logic      restart,
  output logic      pads_on,
  output logic      bad_code
);
  logic [2:0] sync_q [SYNC_STAGES];
  logic [2:0] sync_d [SYNC_STAGES];
  clk_mode_e  mode_q;
  logic       load_en;

  always_comb begin
    sync_d[0] = code_in;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= sync_d[i];
    end
  end

  always_comb begin
    mode_nx = decode_code(sync_q[SYNC_STAGES-1]);
    restart = (mode_nx != mode_q);
    load_en = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_FLOAT;
    else if (load_en) mode_q <= mode_nx;
  end

  assign mode_cur = mode_q;
  assign pads_on  = (mode_q != MD_FLOAT);
  assign bad_code = (mode_q == MD_BAD);
endmodule

// File: rtl/clkgen_div_table.sv
module clkgen_div_table
  import clkgen_pkg::*;
#(
  parameter int CW         = 5,
  parameter int CPU_DIV_66 = 3,
  parameter int CPU_DIV_100= 2,
  parameter int PCI_DIV    = 6,
  parameter int USB_DIV    = 4,
  parameter int REF_DIV    = 14,
  parameter int TST_CPU    = 2,
  parameter int TST_PCI    = 6,
  parameter int TST_USB    = 2,
  parameter int TST_REF    = 1
) (
  input  clk_mode_e        mode,
  output logic [CW-1:0]    div  [NGRP],
  output logic             run  [NGRP]
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int A66  = (g == GRP_CPU) ? CPU_DIV_66  :
                          (g == GRP_USB) ? USB_DIV :
                          (g >= GRP_REF) ? REF_DIV : PCI_DIV;
    localparam int A100 = (g == GRP_CPU) ? CPU_DIV_100 :
                          (g == GRP_USB) ? USB_DIV :
                          (g >= GRP_REF) ? REF_DIV : PCI_DIV;
    localparam int TST  = (g == GRP_CPU) ? TST_CPU :
                          (g == GRP_USB) ? TST_USB :
                          (g >= GRP_REF) ? TST_REF : TST_PCI;
    always_comb begin
      run[g] = mode_runs(mode);
      case (mode)
        MD_RUN66:  div[g] = CW'(A66);
        MD_RUN100: div[g] = CW'(A100);
        MD_TEST:   div[g] = CW'(TST);
        default:   div[g] = CW'(1);
      endcase
    end
  end
endmodule

// File: rtl/clkgen_half_div.sv
module clkgen_half_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_nx,
  input  logic [CW-1:0] div_nx,
  input  logic          restart_nx,
  output logic          ck_out
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] div_q;
  logic          run_q;
  logic          rise_q, rise_nx;
  logic          fall_q, fall_nx;
  logic          lvl_rise, lvl_fall;
  logic [CW-1:0] cnt_inc;

  // Next state for the rising-edge half: pick the level of half-cycle 2*cnt.
  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    if (restart_nx || !run_nx)  cnt_nx = '0;
    else if (cnt_inc >= div_nx) cnt_nx = '0;
    else                        cnt_nx = cnt_inc;
    lvl_rise = run_nx && ({cnt_nx, 1'b0} < {1'b0, div_nx});
    rise_nx  = lvl_rise ^ fall_q;
  end

  // Next state for the falling-edge half: level of half-cycle 2*cnt+1.
  always_comb begin
    lvl_fall = run_q && ({cnt_q, 1'b1} < {1'b0, div_q});
    fall_nx  = lvl_fall ^ rise_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= CW'(1);
      run_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      div_q  <= div_nx;
      run_q  <= run_nx;
      rise_q <= rise_nx;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_nx;
  end

  assign ck_out = rise_q ^ fall_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < div_q)); // R9
endmodule

// File: rtl/clkgen_freq_sel.sv
module clkgen_freq_sel
  import clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CPU_DIV_66  = 3,
  parameter int CPU_DIV_100 = 2,
  parameter int PCI_DIV     = 6,
  parameter int USB_DIV     = 4,
  parameter int REF_DIV     = 14,
  parameter int TST_CPU     = 2,
  parameter int TST_PCI     = 6,
  parameter int TST_USB     = 2,
  parameter int TST_REF     = 1
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [2:0] sel_code,
  output logic       cpu_ck,
  output logic       pci_ck,
  output logic       pcif_ck,
  output logic       usb_ck,
  output logic       ref_ck,
  output logic       apic_ck,
  output logic       cpu_oe,
  output logic       pci_oe,
  output logic       pcif_oe,
  output logic       usb_oe,
  output logic       ref_oe,
  output logic       apic_oe,
  output logic       mode_err
);
  localparam int MAX_A  = (REF_DIV > PCI_DIV) ? REF_DIV : PCI_DIV;
  localparam int MAX_B  = (USB_DIV > TST_PCI) ? USB_DIV : TST_PCI;
  localparam int MAX_DV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_DV + 1) + 1;

  logic          rst_n_s;
  clk_mode_e     mode_nx, mode_cur;
  logic          restart, pads_on, bad_code;
  logic [CW-1:0] div  [NGRP];
  logic          run  [NGRP];
  logic [NGRP-1:0] ck;

  clkgen_rst_sync #(.STAGES(2)) u_rst (
    .clk(mclk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  clkgen_mode_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(mclk), .rst_n(rst_n_s), .code_in(sel_code),
    .mode_nx(mode_nx), .mode_cur(mode_cur), .restart(restart),
    .pads_on(pads_on), .bad_code(bad_code));

  clkgen_div_table #(
    .CW(CW), .CPU_DIV_66(CPU_DIV_66), .CPU_DIV_100(CPU_DIV_100),
    .PCI_DIV(PCI_DIV), .USB_DIV(USB_DIV), .REF_DIV(REF_DIV),
    .TST_CPU(TST_CPU), .TST_PCI(TST_PCI), .TST_USB(TST_USB),
    .TST_REF(TST_REF)
  ) u_tbl (.mode(mode_nx), .div(div), .run(run));

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    clkgen_half_div #(.CW(CW)) u_div (
      .clk(mclk), .rst_n(rst_n_s), .run_nx(run[g]), .div_nx(div[g]),
      .restart_nx(restart), .ck_out(ck[g]));
  end

  assign cpu_ck   = ck[GRP_CPU];
  assign pci_ck   = ck[GRP_PCI];
  assign pcif_ck  = ck[GRP_PCIF];
  assign usb_ck   = ck[GRP_USB];
  assign ref_ck   = ck[GRP_REF];
  assign apic_ck  = ck[GRP_APIC];
  assign cpu_oe   = pads_on;
  assign pci_oe   = pads_on;
  assign pcif_oe  = pads_on;
  assign usb_oe   = pads_on;
  assign ref_oe   = pads_on;
  assign apic_oe  = pads_on;
  assign mode_err = bad_code;

  AST_PCI_AFTER_CPU: assert property (@(posedge mclk) disable iff (!rst_n_s)
    $rose(pci_ck) |-> $rose(cpu_ck)); // R8
  AST_FLOAT_LOW: assert property (@(posedge mclk) disable iff (!rst_n_s)
    !cpu_oe |-> (!cpu_ck && !pci_ck && !usb_ck)); // R2
  AST_BAD_QUIET: assert property (@(posedge mclk) disable iff (!rst_n_s)
    mode_err |-> (!cpu_ck && !pci_ck && !pcif_ck && !usb_ck && cpu_oe)); // R7
  AST_PCIF_MATCH: assert property (@(posedge mclk) disable iff (!rst_n_s)
    (mode_cur == MD_RUN66) |-> (pci_ck == pcif_ck)); // R3
endmodule

// File: tb/clkgen_freq_sel_bench.sv
module clkgen_freq_sel_bench;
  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel_code = 3'b000;
  logic cpu_ck, pci_ck, pcif_ck, usb_ck, ref_ck, apic_ck;
  logic cpu_oe, pci_oe, pcif_oe, usb_oe, ref_oe, apic_oe, mode_err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 mclk = ~mclk;

  clkgen_freq_sel u_clkgen_freq_sel (
    .mclk(mclk), .rst_n(rst_n), .sel_code(sel_code),
    .cpu_ck(cpu_ck), .pci_ck(pci_ck), .pcif_ck(pcif_ck), .usb_ck(usb_ck),
    .ref_ck(ref_ck), .apic_ck(apic_ck), .cpu_oe(cpu_oe), .pci_oe(pci_oe),
    .pcif_oe(pcif_oe), .usb_oe(usb_oe), .ref_oe(ref_oe), .apic_oe(apic_oe),
    .mode_err(mode_err));

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // 0 float, 1 run66, 2 run100, 3 test, 4 reserved
  function automatic int kind(input logic [2:0] c);
    case (c)
      3'b000: return 0;
      3'b011: return 1;
      3'b111: return 2;
      3'b100: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_div(input int k, input int g);
    int d;
    case (g)
      0: d = (k == 1) ? 3 : 2;
      1, 2: d = 6;
      3: d = (k == 3) ? 2 : 4;
      default: d = (k == 3) ? 1 : 14;
    endcase
    return d;
  endfunction

  function automatic string tag(input int k, input int g);
    if (k == 0) return "R2";
    if (k == 4) return "R7";
    if (k == 3) return "R6";
    if (g >= 3) return "R5";
    return (k == 1) ? "R3" : "R4";
  endfunction

  function automatic logic grp_ck(input int g);
    case (g)
      0: return cpu_ck;
      1: return pci_ck;
      2: return pcif_ck;
      3: return usb_ck;
      4: return ref_ck;
      default: return apic_ck;
    endcase
  endfunction

  task automatic sample_half(input int k, input int j);
    for (int g = 0; g < 6; g++) begin
      int d = exp_div(k, g);
      int e = ((k >= 1) && (k <= 3) && ((j % (2 * d)) < d)) ? 1 : 0;
      check(tag(k, g), int'(grp_ck(g)), e, $sformatf("group %0d half %0d", g, j));
    end
    if (j == 0) begin
      check("R9", int'(cpu_ck), ((k >= 1) && (k <= 3)) ? 1 : 0, "cpu high after restart");
      check("R8", int'(pci_ck), int'(cpu_ck), "pci rise coincides with cpu");
    end
  endtask

  task automatic run_code(input logic [2:0] c);
    int k = kind(c);
    @(negedge mclk);
    sel_code = (c == 3'b000) ? 3'b001 : 3'b000;
    repeat (10) @(posedge mclk);
    @(negedge mclk);
    sel_code = c;
    repeat (3) @(posedge mclk);
    #2;
    sample_half(k, 0);
    for (int j = 1; j < 36; j++) begin
      if (j % 2 == 1) @(negedge mclk); else @(posedge mclk);
      #2;
      sample_half(k, j);
    end
    check("R1", int'(cpu_oe & pci_oe & pcif_oe & usb_oe & ref_oe & apic_oe),
          (k == 0) ? 0 : 1, $sformatf("all enables code %0d", c));
    check("R1", int'(cpu_oe | pci_oe | pcif_oe | usb_oe | ref_oe | apic_oe),
          (k == 0) ? 0 : 1, $sformatf("any enable code %0d", c));
    check((k == 4) ? "R7" : "R1", int'(mode_err), (k == 4) ? 1 : 0,
          $sformatf("mode_err code %0d", c));
  endtask

  initial begin
    repeat (3) @(posedge mclk);
    #2;
    check("R10", int'(cpu_ck | pci_ck | pcif_ck | usb_ck | ref_ck | apic_ck), 0, "clocks in reset");
    check("R10", int'(cpu_oe | pci_oe | usb_oe | ref_oe), 0, "enables in reset");
    @(negedge mclk);
    rst_n = 1'b1;
    repeat (8) @(posedge mclk);
    #2;
    check("R10", int'(cpu_ck | pci_ck | pcif_ck | usb_ck | ref_ck | apic_ck), 0, "clocks after reset");
    check("R10", int'(cpu_oe | pcif_oe | apic_oe | mode_err), 0, "enables/err after reset");
    for (int c = 0; c < 8; c++) run_code(3'(c));
    run_code(3'b011);
    run_code(3'b111);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule